// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of an unpipelined 32-bit load/store processor that completes one instruction per clock. Each cycle it looks at the 6-bit major opcode of the fetched instruction, at the data leaving the first register read port and at a pending interrupt request. From these it produces every select and enable that steers the datapath: the next-PC source, the address source of the second register read port, both ALU operand selects, the register write-back source and address, the ALU function, the register file write enable and the memory write strobe.

The decode is purely combinational. The only exception is one flag that keeps the memory write strobe low while reset is held and until the first rising clock edge after reset is released. The zero test that conditions branches is made inside the block from the raw read-port data. A pending interrupt takes priority over the opcode. It forces a jump to the interrupt handler and writes the return address into the dedicated exception register.

Top module: `ctl_decoder`

## Requirements
- R1: Opcodes 0x20–0x2E, except 0x27, are register-register ALU operations. They drive opb_sel_o=0, wb_src_o=1 (ALU result), rf_we_o=1, mem_we_o=0, pc_src_o=0, and alu_op_o equal to opcode bits [3:0].
- R2: Opcodes 0x30–0x3E, except 0x37, are the literal forms of the same ALU operations, for example 0x32 multiply-by-constant and 0x3C shift-left-by-constant. They drive the same values as R1, except that opb_sel_o=1 (sign-extended literal).
- R3: Store (0x19) drives rb_sel_o=1, mem_we_o=1, rf_we_o=0, opb_sel_o=1 and alu_op_o=0 (add). rb_sel_o is 0 for every other opcode and whenever an interrupt is pending.
- R4: Load (0x18) drives opb_sel_o=1, alu_op_o=0, wb_src_o=2 (memory data), rf_we_o=1 and mem_we_o=0.
- R5: PC-relative load (0x1F) drives opa_sel_o=1 (PC-relative operand), opb_sel_o=1, alu_op_o=0xF (pass operand A), wb_src_o=2 and rf_we_o=1.
- R6: Register jump (0x1B) drives pc_src_o=2, wb_src_o=0 (PC+4) and rf_we_o=1.
- R7: Branch-if-zero (0x1C) and branch-if-nonzero (0x1D) drive wb_src_o=0 and rf_we_o=1. pc_src_o is 1 (branch target) when the condition holds and 0 otherwise. The zero flag is 1 exactly when every bit of ra_data_i is 0.
- R8: Every opcode not listed in R1–R7 is illegal. It drives pc_src_o=3 (illegal-op handler), wb_addr_sel_o=1 (exception register), wb_src_o=0, rf_we_o=1 and mem_we_o=0.
- R9: When irq_i=1, the opcode is ignored. The outputs are pc_src_o=4 (interrupt handler), wb_addr_sel_o=1, wb_src_o=0, rf_we_o=1 and mem_we_o=0.
- R10: mem_we_o is 0 while rst_ni is low and until the first rising clk_i edge after rst_ni goes high. The other outputs follow the decode during that window.
- R11: Fields not named for a case are 0. pc_src_o is 0 for non-branching legal opcodes, opa_sel_o is 0 except for R5, wb_addr_sel_o is 0 except for R8 and R9, and alu_op_o is 0 for jump, branches, traps and interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only for the post-reset write-enable flag |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 6 | Major opcode field of the current instruction |
| ra_data_i | input | 32 | Data from the first register read port |
| irq_i | input | 1 | Pending interrupt request |
| pc_src_o | output | 3 | Next-PC source: 0 PC+4, 1 branch target, 2 register, 3 illegal handler, 4 interrupt handler |
| rb_sel_o | output | 1 | Second read-port address: 0 Rb field, 1 Rc field |
| opa_sel_o | output | 1 | ALU operand A: 0 register, 1 PC-relative offset |
| opb_sel_o | output | 1 | ALU operand B: 0 register, 1 sign-extended literal |
| wb_src_o | output | 2 | Write-back data: 0 PC+4, 1 ALU, 2 memory |
| alu_op_o | output | 4 | ALU function code |
| mem_we_o | output | 1 | Memory write strobe |
| rf_we_o | output | 1 | Register file write enable |
| wb_addr_sel_o | output | 1 | Write address: 0 Rc field, 1 exception register |

## Verification
The assertions check the cross-output rules on every cycle:
- the second-port select appears only for a store;
- a memory write never coincides with a register write;
- redirecting the write address always comes with a PC+4 write-back;
- an interrupt always forces the handler vector with no store;
- the branch PC source always agrees with the zero test of the read data;
- no store strobe appears while reset is held.

The exact per-opcode value of each field comes from the bench's scenarios. These cover an exhaustive sweep of all 64 opcodes with zero and non-zero read data, random mixes with interrupts, and the cycle just after reset release. Only those scenarios can show that the literal and register forms differ in the operand-B select alone.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPC_W   = 6;
  localparam int PCSRC_W = 3;
  localparam int WBSRC_W = 2;
  localparam int ALUOP_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD     = 6'h18;
  localparam logic [OPC_W-1:0] OPC_STORE    = 6'h19;
  localparam logic [OPC_W-1:0] OPC_JUMP     = 6'h1B;
  localparam logic [OPC_W-1:0] OPC_BR_ZERO  = 6'h1C;
  localparam logic [OPC_W-1:0] OPC_BR_NZERO = 6'h1D;
  localparam logic [OPC_W-1:0] OPC_LOAD_REL = 6'h1F;

  localparam logic [PCSRC_W-1:0] PC_SEQ    = 3'd0;
  localparam logic [PCSRC_W-1:0] PC_BRANCH = 3'd1;
  localparam logic [PCSRC_W-1:0] PC_REG    = 3'd2;
  localparam logic [PCSRC_W-1:0] PC_ILLOP  = 3'd3;
  localparam logic [PCSRC_W-1:0] PC_IRQ    = 3'd4;

  localparam logic [WBSRC_W-1:0] WB_PC4 = 2'd0;
  localparam logic [WBSRC_W-1:0] WB_ALU = 2'd1;
  localparam logic [WBSRC_W-1:0] WB_MEM = 2'd2;

  localparam logic [ALUOP_W-1:0] ALU_ADD    = 4'h0;
  localparam logic [ALUOP_W-1:0] ALU_PASS_A = 4'hF;

  typedef enum logic [3:0] {
    CLS_ALU_RR,
    CLS_ALU_LIT,
    CLS_LOAD,
    CLS_LOAD_REL,
    CLS_STORE,
    CLS_JUMP,
    CLS_BR_ZERO,
    CLS_BR_NZERO,
    CLS_ILLEGAL
  } instr_cls_e;

  typedef struct packed {
    logic [PCSRC_W-1:0] pc_src;
    logic               rb_sel;
    logic               opa_sel;
    logic               opb_sel;
    logic [WBSRC_W-1:0] wb_src;
    logic [ALUOP_W-1:0] alu_op;
    logic               mem_we;
    logic               rf_we;
    logic               wb_addr_sel;
  } ctl_word_t;

  localparam ctl_word_t CTL_IDLE = '0;
endpackage

// File: rtl/ctl_zero_detect.sv
module ctl_zero_detect #(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              zero_o
);
  localparam int N_CHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W   = N_CHUNK * CHUNK_W;

  logic [PAD_W-1:0]   padded;
  logic [N_CHUNK-1:0] chunk_nz;

  assign padded = PAD_W'(data_i);

  // two-level OR tree keeps depth bounded for wide datapaths
  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    assign chunk_nz[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end

  assign zero_o = ~|chunk_nz;
endmodule

// File: rtl/ctl_opcode_class.sv
module ctl_opcode_class
  import ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output instr_cls_e       cls_o
);
  logic alu_fn_ok;

  // function nibbles 7 and F are unassigned
  assign alu_fn_ok = (opcode_i[2:0] != 3'b111);

  always_comb begin
    cls_o = CLS_ILLEGAL;
    if (opcode_i[5:4] == 2'b10 && alu_fn_ok) begin
      cls_o = CLS_ALU_RR;
    end else if (opcode_i[5:4] == 2'b11 && alu_fn_ok) begin
      cls_o = CLS_ALU_LIT;
    end else begin
      case (opcode_i)
        OPC_LOAD:     cls_o = CLS_LOAD;
        OPC_STORE:    cls_o = CLS_STORE;
        OPC_JUMP:     cls_o = CLS_JUMP;
        OPC_BR_ZERO:  cls_o = CLS_BR_ZERO;
        OPC_BR_NZERO: cls_o = CLS_BR_NZERO;
        OPC_LOAD_REL: cls_o = CLS_LOAD_REL;
        default:      cls_o = CLS_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/ctl_signal_gen.sv
module ctl_signal_gen
  import ctl_pkg::*;
(
  input  instr_cls_e         cls_i,
  input  logic [ALUOP_W-1:0] alu_fn_i,
  input  logic               zero_i,
  output ctl_word_t          ctl_o
);
  always_comb begin
    ctl_o = CTL_IDLE;
    unique case (cls_i)
      CLS_ALU_RR, CLS_ALU_LIT: begin
        ctl_o.opb_sel = (cls_i == CLS_ALU_LIT);
        ctl_o.wb_src  = WB_ALU;
        ctl_o.alu_op  = alu_fn_i;
        ctl_o.rf_we   = 1'b1;
      end
      CLS_LOAD: begin
        ctl_o.opb_sel = 1'b1;
        ctl_o.wb_src  = WB_MEM;
        ctl_o.alu_op  = ALU_ADD;
        ctl_o.rf_we   = 1'b1;
      end
      CLS_LOAD_REL: begin
        ctl_o.opa_sel = 1'b1;
        ctl_o.opb_sel = 1'b1;
        ctl_o.wb_src  = WB_MEM;
        ctl_o.alu_op  = ALU_PASS_A;
        ctl_o.rf_we   = 1'b1;
      end
      CLS_STORE: begin
        ctl_o.rb_sel  = 1'b1;
        ctl_o.opb_sel = 1'b1;
        ctl_o.alu_op  = ALU_ADD;
        ctl_o.mem_we  = 1'b1;
      end
      CLS_JUMP: begin
        ctl_o.pc_src = PC_REG;
        ctl_o.wb_src = WB_PC4;
        ctl_o.rf_we  = 1'b1;
      end
      CLS_BR_ZERO, CLS_BR_NZERO: begin
        ctl_o.pc_src = ((cls_i == CLS_BR_ZERO) == zero_i) ? PC_BRANCH : PC_SEQ;
        ctl_o.wb_src = WB_PC4;
        ctl_o.rf_we  = 1'b1;
      end
      default: begin
        ctl_o.pc_src      = PC_ILLOP;
        ctl_o.wb_src      = WB_PC4;
        ctl_o.rf_we       = 1'b1;
        ctl_o.wb_addr_sel = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [DATA_W-1:0]   ra_data_i,
  input  logic                irq_i,
  output logic [PCSRC_W-1:0]  pc_src_o,
  output logic                rb_sel_o,
  output logic                opa_sel_o,
  output logic                opb_sel_o,
  output logic [WBSRC_W-1:0]  wb_src_o,
  output logic [ALUOP_W-1:0]  alu_op_o,
  output logic                mem_we_o,
  output logic                rf_we_o,
  output logic                wb_addr_sel_o
);
  instr_cls_e cls;
  logic       ra_zero;
  logic       run_q;
  ctl_word_t  dec_word;
  ctl_word_t  fin_word;

  ctl_zero_detect #(.DATA_W(DATA_W)) u_zero (
    .data_i (ra_data_i),
    .zero_o (ra_zero)
  );

  ctl_opcode_class u_class (
    .opcode_i (opcode_i),
    .cls_o    (cls)
  );

  ctl_signal_gen u_gen (
    .cls_i    (cls),
    .alu_fn_i (opcode_i[ALUOP_W-1:0]),
    .zero_i   (ra_zero),
    .ctl_o    (dec_word)
  );

  // stores held off until the first fetch edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  always_comb begin
    fin_word = dec_word;
    if (irq_i) begin
      fin_word             = CTL_IDLE;
      fin_word.pc_src      = PC_IRQ;
      fin_word.wb_src      = WB_PC4;
      fin_word.rf_we       = 1'b1;
      fin_word.wb_addr_sel = 1'b1;
    end
    fin_word.mem_we = fin_word.mem_we & run_q;
  end

  assign pc_src_o      = fin_word.pc_src;
  assign rb_sel_o      = fin_word.rb_sel;
  assign opa_sel_o     = fin_word.opa_sel;
  assign opb_sel_o     = fin_word.opb_sel;
  assign wb_src_o      = fin_word.wb_src;
  assign alu_op_o      = fin_word.alu_op;
  assign mem_we_o      = fin_word.mem_we;
  assign rf_we_o       = fin_word.rf_we;
  assign wb_addr_sel_o = fin_word.wb_addr_sel;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
  import ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OPC_W-1:0]   opcode_i,
  input logic [DATA_W-1:0]  ra_data_i,
  input logic               irq_i,
  input logic [PCSRC_W-1:0] pc_src_o,
  input logic               rb_sel_o,
  input logic               opa_sel_o,
  input logic               opb_sel_o,
  input logic [WBSRC_W-1:0] wb_src_o,
  input logic [ALUOP_W-1:0] alu_op_o,
  input logic               mem_we_o,
  input logic               rf_we_o,
  input logic               wb_addr_sel_o
);
  AST_RB_SEL_STORE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_sel_o |-> (opcode_i == OPC_STORE && !irq_i)); // R3

  AST_STORE_NO_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!rf_we_o && opcode_i == OPC_STORE)); // R3

  AST_TRAP_SAVES_PC4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_addr_sel_o |-> (rf_we_o && wb_src_o == WB_PC4 && pc_src_o >= PC_ILLOP)); // R8

  AST_IRQ_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (pc_src_o == PC_IRQ && wb_addr_sel_o && !mem_we_o)); // R9

  AST_BR_ZERO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_BR_ZERO && !irq_i) |-> (pc_src_o == ((ra_data_i == '0) ? PC_BRANCH : PC_SEQ))); // R7

  AST_BR_NZERO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OPC_BR_NZERO && !irq_i) |-> (pc_src_o == ((ra_data_i != '0) ? PC_BRANCH : PC_SEQ))); // R7

  AST_NO_STORE_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_we_o); // R10

  AST_OPA_REL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opa_sel_o |-> (opcode_i == OPC_LOAD_REL && !irq_i)); // R11
endmodule

bind ctl_decoder ctl_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [31:0] ra_data;
  logic        irq;
  logic [2:0]  pc_src;
  logic        rb_sel, opa_sel, opb_sel, mem_we, rf_we, wb_addr_sel;
  logic [1:0]  wb_src;
  logic [3:0]  alu_op;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ctl_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .ra_data_i(ra_data), .irq_i(irq),
    .pc_src_o(pc_src), .rb_sel_o(rb_sel), .opa_sel_o(opa_sel), .opb_sel_o(opb_sel),
    .wb_src_o(wb_src), .alu_op_o(alu_op), .mem_we_o(mem_we), .rf_we_o(rf_we),
    .wb_addr_sel_o(wb_addr_sel)
  );

  // packed as {pc_src,rb,opa,opb,wb_src,alu_op,mem_we,rf_we,wb_addr}
  function automatic logic [15:0] pack(input logic [2:0] p, input logic rb, input logic a,
                                       input logic b, input logic [1:0] w, input logic [3:0] f,
                                       input logic mw, input logic rw, input logic wa);
    return {p, rb, a, b, w, f, mw, rw, wa};
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic ir);
    if (ir) return "R9";
    if (op[5:4] == 2'b10 && op[2:0] != 3'b111) return "R1";
    if (op[5:4] == 2'b11 && op[2:0] != 3'b111) return "R2";
    case (op)
      6'h19: return "R3";
      6'h18: return "R4";
      6'h1F: return "R5";
      6'h1B: return "R6";
      6'h1C, 6'h1D: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] expect_of(input logic [5:0] op, input logic [31:0] d,
                                            input logic ir, input logic run);
    logic z;
    z = (d == 32'd0);
    if (ir) return pack(3'd4, 0, 0, 0, 2'd0, 4'h0, 0, 1, 1);
    if (op[5:4] == 2'b10 && op[2:0] != 3'b111) return pack(3'd0, 0, 0, 0, 2'd1, op[3:0], 0, 1, 0);
    if (op[5:4] == 2'b11 && op[2:0] != 3'b111) return pack(3'd0, 0, 0, 1, 2'd1, op[3:0], 0, 1, 0);
    case (op)
      6'h19: return pack(3'd0, 1, 0, 1, 2'd0, 4'h0, run, 0, 0);
      6'h18: return pack(3'd0, 0, 0, 1, 2'd2, 4'h0, 0, 1, 0);
      6'h1F: return pack(3'd0, 0, 1, 1, 2'd2, 4'hF, 0, 1, 0);
      6'h1B: return pack(3'd2, 0, 0, 0, 2'd0, 4'h0, 0, 1, 0);
      6'h1C: return pack(z ? 3'd1 : 3'd0, 0, 0, 0, 2'd0, 4'h0, 0, 1, 0);
      6'h1D: return pack(z ? 3'd0 : 3'd1, 0, 0, 0, 2'd0, 4'h0, 0, 1, 0);
      default: return pack(3'd3, 0, 0, 0, 2'd0, 4'h0, 0, 1, 1);
    endcase
  endfunction

  task automatic compare(input string req, input logic [15:0] exp_v);
    logic [15:0] act;
    act = pack(pc_src, rb_sel, opa_sel, opb_sel, wb_src, alu_op, mem_we, rf_we, wb_addr_sel);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%h data=%h irq=%b actual=%h expected=%h",
               req, opcode, ra_data, irq, act, exp_v);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [31:0] d, input logic ir,
                       input logic run, input string req);
    @(negedge clk);
    opcode = op; ra_data = d; irq = ir;
    #1;
    compare(req, expect_of(op, d, ir, run));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; opcode = 6'h19; ra_data = 32'h1; irq = 1'b0;
    // R10: store decoded during reset, strobe held low
    apply(6'h19, 32'h5, 1'b0, 1'b0, "R10");
    apply(6'h19, 32'h0, 1'b0, 1'b0, "R10");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R10", expect_of(6'h19, 32'h0, 1'b0, 1'b0)); // before first edge after release
    apply(6'h19, 32'h0, 1'b0, 1'b1, "R3");

    // exhaustive opcode sweep, zero and non-zero read data (R1-R8, R11 fields)
    for (int op = 0; op < 64; op++) begin
      apply(6'(op), 32'h0, 1'b0, 1'b1, req_of(6'(op), 1'b0));
      apply(6'(op), 32'h8000_0000, 1'b0, 1'b1, req_of(6'(op), 1'b0));
    end

    // directed corners
    apply(6'h32, 32'h0, 1'b0, 1'b1, "R2");   // multiply-by-constant
    apply(6'h3C, 32'h1, 1'b0, 1'b1, "R2");   // shift-left-by-constant
    apply(6'h27, 32'h1, 1'b0, 1'b1, "R8");
    apply(6'h37, 32'h1, 1'b0, 1'b1, "R8");
    apply(6'h1C, 32'h0000_0001, 1'b0, 1'b1, "R7");
    apply(6'h1D, 32'h0000_0001, 1'b0, 1'b1, "R7");
    apply(6'h19, 32'h0, 1'b1, 1'b1, "R9");   // interrupt suppresses store
    apply(6'h1F, 32'h0, 1'b1, 1'b1, "R9");
    apply(6'h1B, 32'h0, 1'b0, 1'b1, "R6");
    apply(6'h1F, 32'h3, 1'b0, 1'b1, "R5");
    apply(6'h18, 32'h3, 1'b0, 1'b1, "R4");
    apply(6'h00, 32'h3, 1'b0, 1'b1, "R11");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  rop;
      logic [31:0] rd;
      logic        ri;
      rop = 6'($urandom_range(0, 63));
      rd  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      ri  = ($urandom_range(0, 9) == 0);
      apply(rop, rd, ri, 1'b1, req_of(rop, ri));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule